// File: doc/BRIEF.md
# Packet Payload XOR Cipher Stage

This stage sits in a packet-switching datapath between the output-port lookup and the output queues. Packets arrive as 64-bit words on a data/ctrl/write/ready handshake. Each packet starts with one or more internal header words, which are marked by a nonzero control byte. These are followed by the frame words, whose control byte is zero. A nonzero control byte on a frame word marks that word as the last one of the packet.

The stage forwards the internal header words as they are. It also forwards the Ethernet header and the IPv4 header (14 + 20 bytes, no options) as they are. Every frame byte after the 34th is XORed with a 32-bit key, and the key is repeated twice to cover the 64-bit word. XOR is its own inverse, so the same stage encrypts and decrypts. The 34-byte boundary falls inside the fifth frame word, so that one word is masked per byte lane.

Input words enter a small fall-through FIFO. A separate write strobe loads the key register.

Top module: `pkt_xor_stage`

## Requirements
- R1: After reset, `out_wr` is 0 and `in_rdy` is 1. The key is zero, so a packet sent before any key write leaves the stage unchanged.
- R2: Words with a nonzero `in_ctrl` that arrive before the first frame word of a packet pass unchanged, whatever their number.
- R3: Frame words 0 to 3 (frame bytes 1 to 32) pass unchanged. Frame byte 1 occupies bits [63:56] of frame word 0.
- R4: In frame word 4, bits [63:48] (frame bytes 33 and 34) pass unchanged. Bits [47:0] (frame bytes 35 to 40) are XORed with the same bits of `{key,key}`.
- R5: Frame words 5 and later are XORed over all 64 bits with `{key,key}`, where the key occupies bits [63:32] and again bits [31:0].
- R6: `out_ctrl` equals the control byte of the same word. A frame word with a nonzero control byte is transformed according to its position and ends the packet. The next word is then treated as an internal header word if its control byte is nonzero, and as frame word 0 if it is zero.
- R7: Sending a packet's output back through the stage with the same key gives back the original packet.
- R8: `out_wr` is high only in the cycle after the FIFO held a word while `out_rdy` was high. Words leave in arrival order, and none leave while `out_rdy` stays low.
- R9: `in_rdy` is low while the FIFO holds DEPTH-2 or more words (6 with the default depth of 8). A backlog built under a stall loses no word.
- R10: A cycle with `key_wr_en` high loads `key_wr_data`. Words that leave after that cycle use the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Upstream word |
| in_ctrl | input | 8 | Upstream control byte (nonzero: internal header or last frame word) |
| in_wr | input | 1 | Upstream word valid |
| in_rdy | output | 1 | Stage can take words (FIFO not nearly full) |
| out_data | output | 64 | Transformed word |
| out_ctrl | output | 8 | Control byte forwarded unchanged |
| out_wr | output | 1 | Downstream word valid |
| out_rdy | input | 1 | Downstream can take a word |
| key_wr_en | input | 1 | Key register load strobe |
| key_wr_data | input | 32 | New key value |

## Verification
The overflow assertion takes for granted that upstream raises `in_wr` only while the FIFO is below full. The bench keeps within this by writing a word only after it has seen `in_rdy` high at the preceding falling edge, which leaves a two-entry margin. The position checks take for granted that every packet has at least one frame word, and that its last frame word is the only frame word with a nonzero control byte. The bench loads the key only while the stage is drained, so no packet sees two keys.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  // Word-position classes of the framing state machine
  typedef enum logic [1:0] {
    ST_SKIP = 2'd0,  // internal header words, waiting for frame word 0
    ST_HEAD = 2'd1,  // whole words of the plain Ethernet/IPv4 header
    ST_EDGE = 2'd2,  // word where the cipher begins mid-word
    ST_BODY = 2'd3   // payload, fully ciphered
  } pxs_state_e;
endpackage

// File: rtl/pxs_fifo.sv
module pxs_fifo #(
  parameter int W      = 72,
  parameter int DEPTH  = 8,
  parameter int MARGIN = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         nearly_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             full, push, pop;

  assign full        = (count == CNT_W'(DEPTH));
  assign empty       = (count == '0);
  assign nearly_full = (count >= CNT_W'(DEPTH - MARGIN));
  assign push        = wr_en && !full;
  assign pop         = rd_en && !empty;
  assign rd_data     = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full)
    else $error("write into a full FIFO");

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count != '0))
    else $error("occupancy lost after a write");
endmodule

// File: rtl/pxs_key_reg.sv
module pxs_key_reg #(
  parameter int KW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [KW-1:0] wr_data,
  output logic [KW-1:0] key
);
  always_ff @(posedge clk) begin
    if (rst)        key <= '0;
    else if (wr_en) key <= wr_data;
  end

  // R10
  key_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (key == $past(wr_data)))
    else $error("key register missed a load");
endmodule

// File: rtl/pxs_frame_fsm.sv
module pxs_frame_fsm
  import pxs_pkg::*;
#(
  parameter int NL        = 8,   // byte lanes per word
  parameter int CW        = 8,
  parameter int HDR_BYTES = 34   // plain bytes at the frame start
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [CW-1:0] ctrl_in,
  output logic [NL-1:0] xor_lanes,
  output pxs_state_e    state
);
  localparam int FULL_WORDS = HDR_BYTES / NL;
  localparam int EDGE_LANES = HDR_BYTES % NL;
  localparam int IW         = $clog2(FULL_WORDS + 2);

  logic [IW-1:0] widx, nidx;
  logic [NL-1:0] edge_mask;
  logic          is_ctl;

  // lane bit l covers data bits [8l+7:8l]; byte position i (0 = MSB lane) is bit NL-1-i
  for (genvar i = 0; i < NL; i++) begin : g_edge
    assign edge_mask[NL-1-i] = (i >= EDGE_LANES);
  end

  function automatic pxs_state_e cls_of(input logic [IW-1:0] n);
    if (n < IW'(FULL_WORDS))       return ST_HEAD;
    else if (n == IW'(FULL_WORDS)) return ST_EDGE;
    else                           return ST_BODY;
  endfunction

  assign is_ctl = (ctrl_in != '0);
  assign nidx   = (widx == IW'(FULL_WORDS + 1)) ? widx : widx + 1'b1;

  always_comb begin
    case (state)
      ST_EDGE: xor_lanes = edge_mask;
      ST_BODY: xor_lanes = '1;
      default: xor_lanes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SKIP;
      widx  <= '0;
    end else if (adv) begin
      if (state == ST_SKIP) begin
        if (!is_ctl) begin
          widx  <= IW'(1);
          state <= cls_of(IW'(1));
        end
      end else if (is_ctl) begin
        widx  <= '0;
        state <= ST_SKIP;
      end else begin
        widx  <= nidx;
        state <= cls_of(nidx);
      end
    end
  end

  // R6
  eop_return_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && state != ST_SKIP && is_ctl) |=> (state == ST_SKIP))
    else $error("last frame word did not restart header skip");

  // R2
  skip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && state == ST_SKIP && is_ctl) |=> (state == ST_SKIP))
    else $error("internal header word left skip state");

  // R4
  edge_then_body_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && state == ST_EDGE && !is_ctl) |=> (state == ST_BODY))
    else $error("boundary word not followed by payload class");
endmodule

// File: rtl/pkt_xor_stage.sv
module pkt_xor_stage
  import pxs_pkg::*;
#(
  parameter int DW         = 64,
  parameter int CW         = 8,
  parameter int KW         = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int RDY_MARGIN = 2,
  parameter int HDR_BYTES  = 34
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_ctrl,
  input  logic          in_wr,
  output logic          in_rdy,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_ctrl,
  output logic          out_wr,
  input  logic          out_rdy,
  input  logic          key_wr_en,
  input  logic [KW-1:0] key_wr_data
);
  localparam int NL   = DW / 8;
  localparam int KREP = DW / KW;

  logic [DW-1:0] f_data, key_wide, xmask;
  logic [CW-1:0] f_ctrl;
  logic          f_empty, f_nfull, pop;
  logic [KW-1:0] key;
  logic [NL-1:0] lanes;
  pxs_state_e    fsm_state;

  pxs_fifo #(.W(DW + CW), .DEPTH(FIFO_DEPTH), .MARGIN(RDY_MARGIN)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(in_wr), .wr_data({in_ctrl, in_data}),
    .rd_en(pop), .rd_data({f_ctrl, f_data}),
    .empty(f_empty), .nearly_full(f_nfull)
  );

  pxs_key_reg #(.KW(KW)) u_key (
    .clk(clk), .rst(rst), .wr_en(key_wr_en), .wr_data(key_wr_data), .key(key)
  );

  pxs_frame_fsm #(.NL(NL), .CW(CW), .HDR_BYTES(HDR_BYTES)) u_fsm (
    .clk(clk), .rst(rst), .adv(pop), .ctrl_in(f_ctrl),
    .xor_lanes(lanes), .state(fsm_state)
  );

  assign key_wide = {KREP{key}};
  assign pop      = !f_empty && out_rdy;
  assign in_rdy   = !f_nfull;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign xmask[8*l +: 8] = {8{lanes[l]}} & key_wide[8*l +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr   <= 1'b0;
      out_data <= '0;
      out_ctrl <= '0;
    end else begin
      out_wr   <= pop;
      out_data <= f_data ^ xmask;
      out_ctrl <= f_ctrl;
    end
  end

  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> $past(out_rdy))
    else $error("word sent without downstream ready");

  // R8
  wr_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> !$past(f_empty))
    else $error("word sent from an empty FIFO");

  // R6
  skip_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && fsm_state == ST_SKIP) |=> (out_data == $past(f_data)))
    else $error("header-phase word altered");
endmodule

// File: tb/pkt_xor_stage_tb.sv
module pkt_xor_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QN = 1024;

  logic        clk = 0, rst = 1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 0, out_rdy = 1, key_wr_en = 0;
  logic [31:0] key_wr_data = '0;
  logic        in_rdy, out_wr;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;

  pkt_xor_stage u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .key_wr_en(key_wr_en), .key_wr_data(key_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  bit done = 0;

  // expected stream, filled by the driver, consumed by the monitor
  logic [63:0] exp_d [QN];
  logic [7:0]  exp_c [QN];
  int          exp_t [QN];
  logic [63:0] cap_d [QN];
  int wr_ptr = 0, rd_ptr = 0;

  // bench model state
  logic [31:0] cur_key = '0;
  bit          in_frame = 0;
  int          fidx = 0;

  function automatic string tag_of(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] mk(input int s);
    return 64'h0F1E_2D3C_4B5A_6978 ^ (64'(s) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one word into the stage, with its expected output recorded
  task automatic send_word(input logic [63:0] d, input logic [7:0] c);
    logic [63:0] e, kk;
    int t;
    kk = {cur_key, cur_key};
    e = d;
    if (!in_frame && c != 0) t = 2;
    else begin
      if (!in_frame) begin in_frame = 1; fidx = 0; end
      for (int i = 0; i < 8; i++)
        if (fidx * 8 + i + 1 >= 35) e[63-8*i -: 8] = d[63-8*i -: 8] ^ kk[63-8*i -: 8];
      t = (fidx < 4) ? 3 : (fidx == 4) ? 4 : 5;
      fidx++;
      if (c != 0) in_frame = 0;
    end
    exp_d[wr_ptr] = e; exp_c[wr_ptr] = c; exp_t[wr_ptr] = t;
    wr_ptr++;
    while (!in_rdy) @(negedge clk);
    in_data = d; in_ctrl = c; in_wr = 1;
    @(negedge clk);
    in_wr = 0;
  endtask

  task automatic send_pkt(input int nhdr, input int nframe, input int seed);
    for (int h = 0; h < nhdr; h++) send_word(mk(seed + h), 8'hFF - 8'(h));
    for (int f = 0; f < nframe; f++)
      send_word(mk(seed + 100 + f), (f == nframe - 1) ? 8'h01 : 8'h00);
  endtask

  task automatic drain();
    int w = 0;
    while (rd_ptr != wr_ptr && w < 300) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    check(rd_ptr == wr_ptr, "R8 drain", 64'(rd_ptr), 64'(wr_ptr));
  endtask

  task automatic load_key(input logic [31:0] k);
    key_wr_data = k; key_wr_en = 1;
    @(negedge clk);
    key_wr_en = 0; cur_key = k;
  endtask

  // monitor: every output word compared in order
  always @(negedge clk) begin
    if (!rst && out_wr) begin
      mon_chk++;
      cap_d[rd_ptr] = out_data;
      if (rd_ptr >= wr_ptr) begin
        mon_fail++;
        $display("FAIL R8 unexpected word actual=%h expected=none", out_data);
      end else begin
        if (out_data !== exp_d[rd_ptr]) begin
          mon_fail++;
          $display("FAIL %s word %0d actual=%h expected=%h", tag_of(exp_t[rd_ptr]), rd_ptr, out_data, exp_d[rd_ptr]);
        end
        mon_chk++;
        if (out_ctrl !== exp_c[rd_ptr]) begin
          mon_fail++;
          $display("FAIL R6 ctrl word %0d actual=%h expected=%h", rd_ptr, out_ctrl, exp_c[rd_ptr]);
        end
      end
      rd_ptr++;
    end
  end

  task automatic t_reset();
    check(out_wr == 0, "R1 out_wr after reset", 64'(out_wr), 0);
    check(in_rdy == 1, "R1 in_rdy after reset", 64'(in_rdy), 1);
    send_pkt(1, 7, 10);  // key still zero: identity (R1)
    drain();
  endtask

  task automatic t_multi_hdr();
    load_key(32'hA5C3_1E77);  // R10
    send_pkt(3, 8, 200);      // R2 R3 R4 R5
    drain();
  endtask

  task automatic t_short_and_edge();
    send_pkt(1, 3, 300);  // R6 ends in plain region
    send_pkt(2, 5, 400);  // ends on boundary word
    send_pkt(1, 6, 500);  // back-to-back follow-up
    drain();
  endtask

  task automatic t_roundtrip();
    logic [63:0] orig [12];
    logic [7:0]  oc [12];
    int s1, s2;
    load_key(32'h3C5A_96F0);
    s1 = wr_ptr;
    for (int j = 0; j < 12; j++) begin
      orig[j] = mk(600 + j);
      oc[j] = (j == 0) ? 8'hFF : (j == 11) ? 8'h01 : 8'h00;
      send_word(orig[j], oc[j]);
    end
    drain();
    s2 = wr_ptr;
    for (int j = 0; j < 12; j++) send_word(cap_d[s1 + j], oc[j]);
    drain();
    for (int j = 0; j < 12; j++)
      check(cap_d[s2 + j] == orig[j], "R7 round trip", cap_d[s2 + j], orig[j]);
  endtask

  task automatic t_backpressure();
    load_key(32'h0BAD_F00D);
    out_rdy = 0;
    send_word(mk(700), 8'hFF);
    for (int f = 0; f < 4; f++) send_word(mk(710 + f), 8'h00);
    check(in_rdy == 1, "R9 in_rdy at 5 words", 64'(in_rdy), 1);
    send_word(mk(714), 8'h00);
    check(in_rdy == 0, "R9 in_rdy at 6 words", 64'(in_rdy), 0);
    repeat (3) @(negedge clk);
    check(out_wr == 0, "R8 stalled output", 64'(out_wr), 0);
    check(rd_ptr == wr_ptr - 6, "R8 nothing left under stall", 64'(rd_ptr), 64'(wr_ptr - 6));
    out_rdy = 1;
    for (int f = 0; f < 3; f++) send_word(mk(720 + f), (f == 2) ? 8'h01 : 8'h00);
    drain();
  endtask

  task automatic t_key_change();
    load_key(32'h1234_5678);  // R10 second value
    send_pkt(1, 7, 800);
    drain();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_multi_hdr();
    t_short_and_edge();
    t_roundtrip();
    t_backpressure();
    t_key_change();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end
endmodule